// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable on-chip model of a synchronous static RAM that needs no idle cycle when the bus turns between reads and writes. Every command (chip selects, read/write select, address, burst advance and byte write enables) is sampled on the rising clock edge. A write's data arrives after its address: one edge later when the part runs flow-through, and two edges later when it runs pipelined. A read that overlaps a write still in flight returns the newer bytes, so read and write commands can follow one another on every cycle.

A static mode input picks the read path. In pipelined mode the array word passes through an output register. In flow-through mode the word goes straight to the data output. Bursts start with a normal command and continue with an advance input. The two low address bits then step in either linear or interleaved order, chosen by a static order input. Words are 18 bits wide, made of two 9-bit bytes, and each byte has its own write enable. An asynchronous output enable and an asynchronous sleep input both gate the data output.

Top module: `lwsram_core`

## Requirements
- R1: A command is accepted only when all three bits of `chipSel` are 1. A cycle with any bit at 0 neither writes the array nor drives read data.
- R2: In flow-through mode (`pipeMode`=0), a read sampled at edge k puts its word on `rdData` with `rdValid`=1 directly after edge k.
- R3: In pipelined mode (`pipeMode`=1), a read sampled at edge k puts its word on `rdData` with `rdValid`=1 directly after edge k+1.
- R4: In flow-through mode, the data for a write sampled at edge k is taken from `wrData` at edge k+1.
- R5: In pipelined mode, the data for a write sampled at edge k is taken from `wrData` at edge k+2.
- R6: Byte b of a word is bits [9b+8:9b]. A write changes byte b only when `byteWe[b]`=1, sampled together with the address.
- R7: Reads and writes may follow each other on consecutive cycles in any order. A pipelined read that comes right after a write to the same address returns the write's enabled bytes merged over the stored word.
- R8: With `advance`=1 and `interleave`=0, the command repeats the type of the command that started the burst, ignores `addr` and `readSel`, keeps the upper address bits, and sets the two low bits to (start + n) mod 4.
- R9: With `advance`=1 and `interleave`=1, the two low address bits of the n-th step are the start bits XOR n.
- R10: `outEn`=0 forces `rdValid` to 0 and `rdData` to 0 at once, without waiting for a clock edge.
- R11: While `sleep`=1, commands are ignored and `rdValid` and `rdData` are 0. Writes already in flight still take their data.
- R12: During reset `rdValid` is 0, `rdData` is 0, and no command is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pipeMode | input | 1 | Static: 1 = pipelined, 0 = flow-through |
| interleave | input | 1 | Static burst order: 1 = interleaved, 0 = linear |
| chipSel | input | 3 | Three chip enables, all active high |
| readSel | input | 1 | 1 = read, 0 = write (new commands only) |
| advance | input | 1 | Continue the current burst |
| addr | input | 8 | Word address |
| byteWe | input | 2 | Per-byte write enables |
| wrData | input | 18 | Late write data |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep |
| rdData | output | 18 | Read data, 0 when not driven |
| rdValid | output | 1 | Read data is driven |

## Verification
The case that matters most is a late write committing on the same edge that a pipelined read loads its output register from the same address. The bench provokes this by issuing a byte-masked write followed directly by a read of that address, with the write data placed on the bus two cycles after the write. The returned word is then compared against the old upper byte joined to the new lower byte. A second collision arises in bursts: the data for earlier burst writes lands while advance commands are still being accepted. This is judged by reading each burst address back afterwards.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  parameter int unsigned ADDR_W  = 8;
  parameter int unsigned BYTE_W  = 9;
  parameter int unsigned BYTES   = 2;
  parameter int unsigned BURST_W = 2;
  parameter int unsigned SEL_N   = 3;
  localparam int unsigned DATA_W = BYTE_W * BYTES;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [BYTES-1:0]  be_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  readNow;    // a read sits in stage 1
    addr_t rdAddr;
    logic  commitEn;   // late write takes wrData at the coming edge
    addr_t commitAddr;
    be_t   commitBe;
    logic  fwdEn;      // commit overlaps the read in stage 1
  } strobe_t;

  function automatic addr_t burstAddr(addr_t base, logic [BURST_W-1:0] cnt, logic inter);
    addr_t a;
    a = base;
    if (inter) a[BURST_W-1:0] = base[BURST_W-1:0] ^ cnt;
    else       a[BURST_W-1:0] = base[BURST_W-1:0] + cnt;
    return a;
  endfunction
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pipeMode,
  input  logic             interleave,
  input  logic [SEL_N-1:0] chipSel,
  input  logic             readSel,
  input  logic             advance,
  input  addr_t            addr,
  input  be_t              byteWe,
  input  logic             sleep,
  output strobe_t          strb
);
  logic selected, isAdvance, cmdValid, cmdWrite;
  addr_t cmdAddr, burstBase;
  logic [BURST_W-1:0] burstCnt, nextCnt;
  logic burstLive, lastWrite;

  logic  s1Valid, s1Write, s2Valid, s2Write;
  addr_t s1Addr, s2Addr;
  be_t   s1Be, s2Be;

  // command decode
  always_comb begin
    selected  = (&chipSel) && !sleep;
    isAdvance = selected && advance && burstLive;
    cmdValid  = selected && (!advance || burstLive);
    nextCnt   = burstCnt + 1'b1;
    if (isAdvance) begin
      cmdAddr  = burstAddr(burstBase, nextCnt, interleave);
      cmdWrite = lastWrite;
    end else begin
      cmdAddr  = addr;
      cmdWrite = !readSel;
    end
  end

  // burst tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstBase <= '0;
      burstCnt  <= '0;
      burstLive <= 1'b0;
      lastWrite <= 1'b0;
    end else if (cmdValid) begin
      if (isAdvance) begin
        burstCnt <= nextCnt;
      end else begin
        burstBase <= addr;
        burstCnt  <= '0;
        burstLive <= 1'b1;
        lastWrite <= !readSel;
      end
    end
  end

  // late-write command pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Addr  <= '0;
      s1Be    <= '0;
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s2Addr  <= '0;
      s2Be    <= '0;
    end else begin
      s1Valid <= cmdValid;
      if (cmdValid) begin
        s1Write <= cmdWrite;
        s1Addr  <= cmdAddr;
        s1Be    <= byteWe;
      end
      s2Valid <= s1Valid;
      s2Write <= s1Write;
      s2Addr  <= s1Addr;
      s2Be    <= s1Be;
    end
  end

  always_comb begin
    strb.readNow = s1Valid && !s1Write;
    strb.rdAddr  = s1Addr;
    if (pipeMode) begin
      strb.commitEn   = s2Valid && s2Write;
      strb.commitAddr = s2Addr;
      strb.commitBe   = s2Be;
      strb.fwdEn      = s1Valid && !s1Write && s2Valid && s2Write && (s2Addr == s1Addr);
    end else begin
      strb.commitEn   = s1Valid && s1Write;
      strb.commitAddr = s1Addr;
      strb.commitBe   = s1Be;
      strb.fwdEn      = 1'b0;
    end
  end

  // R4: flow-through commit uses the write accepted one edge earlier
  p_commit_flow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && strb.commitEn) |-> $past(cmdValid && cmdWrite));

  // R5: pipelined commit uses the write accepted two edges earlier
  p_commit_pipe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && strb.commitEn) |-> $past(cmdValid && cmdWrite, 2));

  // R1: deselected cycle leaves stage 1 empty
  p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(&chipSel) |=> !s1Valid);

  // R11: sleep blocks new commands
  p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !s1Valid);

  // R8: a burst step stays within the aligned group of four
  p_burst_group_r8: assert property (@(posedge clk) disable iff (!rstN)
    isAdvance |=> s1Addr[ADDR_W-1:BURST_W] == $past(s1Addr[ADDR_W-1:BURST_W]));
endmodule

// File: rtl/lwsram_dpath.sv
module lwsram_dpath
  import lwsram_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pipeMode,
  input  logic    outEn,
  input  logic    sleep,
  input  data_t   wrData,
  input  strobe_t strb,
  output data_t   rdData,
  output logic    rdValid
);
  data_t arrWord, merged, outReg, selData;
  logic  outValid, syncDrive, dataDrive;

  // one storage lane per byte, each with its own write enable
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    logic [BYTE_W-1:0] laneRd;
    logic [BYTE_W-1:0] laneIn;

    assign laneIn = wrData[b*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
      if (strb.commitEn && strb.commitBe[b])
        laneMem[strb.commitAddr] <= laneIn;
    end

    assign laneRd = laneMem[strb.rdAddr];
    assign arrWord[b*BYTE_W +: BYTE_W] = laneRd;
    assign merged[b*BYTE_W +: BYTE_W]  = (strb.fwdEn && strb.commitBe[b]) ? laneIn : laneRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outReg   <= '0;
    end else begin
      outValid <= pipeMode && strb.readNow;
      if (strb.readNow) outReg <= merged;
    end
  end

  always_comb begin
    syncDrive = pipeMode ? outValid : strb.readNow;
    selData   = pipeMode ? outReg : arrWord;
    dataDrive = syncDrive && outEn && !sleep;
    rdValid   = dataDrive;
    rdData    = dataDrive ? selData : '0;
  end
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              interleave,
  input  logic [SEL_N-1:0]  chipSel,
  input  logic              readSel,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byteWe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEn,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobe_t strb;

  lwsram_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pipeMode   (pipeMode),
    .interleave (interleave),
    .chipSel    (chipSel),
    .readSel    (readSel),
    .advance    (advance),
    .addr       (addr),
    .byteWe     (byteWe),
    .sleep      (sleep),
    .strb       (strb)
  );

  lwsram_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .outEn    (outEn),
    .sleep    (sleep),
    .wrData   (wrData),
    .strb     (strb),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );
endmodule

// File: tb/lwsram_core_bench.sv
`timescale 1ns/1ps
module lwsram_core_bench;
  import lwsram_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeMode = 1'b1, interleave = 1'b0;
  logic [2:0] chipSel = 3'b000;
  logic readSel = 1'b1, advance = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] byteWe = '0;
  logic [17:0] wrData = '0;
  logic outEn = 1'b1, sleep = 1'b0;
  logic [17:0] rdData;
  logic rdValid;
  int testCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  lwsram_core u_lwsram_core (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .interleave(interleave),
    .chipSel(chipSel), .readSel(readSel), .advance(advance), .addr(addr),
    .byteWe(byteWe), .wrData(wrData), .outEn(outEn), .sleep(sleep),
    .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        rd;
    logic        adv;
    logic [7:0]  ad;
    logic [1:0]  be;
    logic [17:0] wd;
    logic        ev;
    logic [17:0] ed;
  } vec_t;

  // pipelined mode, linear order; expectation observed after the vector's edge
  localparam vec_t VECS [19] = '{
    '{3'b111, 1'b0, 1'b0, 8'h10, 2'b11, 18'h00000, 1'b0, 18'h00000}, // write 0x10
    '{3'b111, 1'b0, 1'b0, 8'h11, 2'b11, 18'h00000, 1'b0, 18'h00000}, // write 0x11
    '{3'b111, 1'b1, 1'b0, 8'h10, 2'b00, 18'h12345, 1'b0, 18'h00000}, // R5 data 0x10
    '{3'b111, 1'b1, 1'b0, 8'h11, 2'b00, 18'h0ABCD, 1'b1, 18'h12345}, // R3 R7
    '{3'b111, 1'b0, 1'b0, 8'h10, 2'b01, 18'h00000, 1'b1, 18'h0ABCD}, // R3 R7
    '{3'b111, 1'b1, 1'b0, 8'h10, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h00077, 1'b1, 18'h12277}, // R7 R6 merge
    '{3'b111, 1'b1, 1'b0, 8'h10, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h00000, 1'b1, 18'h12277}, // R6
    '{3'b111, 1'b0, 1'b0, 8'h22, 2'b11, 18'h00000, 1'b0, 18'h00000}, // burst start
    '{3'b111, 1'b1, 1'b1, 8'h00, 2'b11, 18'h00000, 1'b0, 18'h00000}, // R8 -> 0x23
    '{3'b111, 1'b1, 1'b1, 8'h00, 2'b11, 18'h00111, 1'b0, 18'h00000}, // R8 -> 0x20
    '{3'b111, 1'b1, 1'b1, 8'h00, 2'b11, 18'h00222, 1'b0, 18'h00000}, // R8 -> 0x21
    '{3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h00333, 1'b0, 18'h00000},
    '{3'b111, 1'b1, 1'b0, 8'h20, 2'b00, 18'h00444, 1'b0, 18'h00000},
    '{3'b111, 1'b1, 1'b0, 8'h21, 2'b00, 18'h00000, 1'b1, 18'h00333}, // R8
    '{3'b111, 1'b1, 1'b0, 8'h23, 2'b00, 18'h00000, 1'b1, 18'h00444}, // R8
    '{3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h00000, 1'b1, 18'h00222}, // R8
    '{3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h00000, 1'b0, 18'h00000}
  };

  task automatic chk(input string tag, input logic ev, input logic [17:0] ed);
    testCnt++;
    if (rdValid !== ev || rdData !== (ev ? ed : 18'h0)) begin
      failCnt++;
      $display("FAIL %s: got valid=%0b data=%05h, expected valid=%0b data=%05h",
               tag, rdValid, rdData, ev, ev ? ed : 18'h0);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic rd, input logic adv,
                      input logic [7:0] a, input logic [1:0] be, input logic [17:0] wd);
    chipSel = s; readSel = rd; advance = adv; addr = a; byteWe = be; wrData = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset state", 1'b0, 18'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 19; i++) begin
      step(VECS[i].sel, VECS[i].rd, VECS[i].adv, VECS[i].ad, VECS[i].be, VECS[i].wd);
      chk($sformatf("R3/R5/R7/R8 vector %0d", i), VECS[i].ev, VECS[i].ed);
    end

    // flow-through mode
    rstN = 1'b0; pipeMode = 1'b0;
    step(3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h0);
    chk("R12 reset in flow mode", 1'b0, 18'h0);
    rstN = 1'b1;

    step(3'b111, 1'b0, 1'b0, 8'h40, 2'b11, 18'h0);
    step(3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h3FFFF);
    step(3'b111, 1'b1, 1'b0, 8'h40, 2'b00, 18'h0);
    chk("R2 R4 flow read after late write", 1'b1, 18'h3FFFF);

    step(3'b111, 1'b0, 1'b0, 8'h40, 2'b10, 18'h0);
    step(3'b111, 1'b1, 1'b0, 8'h40, 2'b00, 18'h00000);
    chk("R6 R7 upper byte only, read right after write", 1'b1, 18'h001FF);

    step(3'b110, 1'b0, 1'b0, 8'h40, 2'b11, 18'h0);
    step(3'b110, 1'b1, 1'b0, 8'h40, 2'b00, 18'h00000);
    chk("R1 deselected read not driven", 1'b0, 18'h0);
    step(3'b111, 1'b1, 1'b0, 8'h40, 2'b00, 18'h0);
    chk("R1 deselected write ignored", 1'b1, 18'h001FF);

    outEn = 1'b0; #1;
    chk("R10 output enable low", 1'b0, 18'h0);
    outEn = 1'b1; #1;
    chk("R10 output enable restored", 1'b1, 18'h001FF);

    sleep = 1'b1; #1;
    chk("R11 sleep gates output", 1'b0, 18'h0);
    step(3'b111, 1'b0, 1'b0, 8'h40, 2'b11, 18'h0);
    sleep = 1'b0;
    step(3'b111, 1'b1, 1'b0, 8'h40, 2'b00, 18'h00000);
    chk("R11 write during sleep ignored", 1'b1, 18'h001FF);

    // interleaved write burst from 0x51: 51,50,53,52
    interleave = 1'b1;
    step(3'b111, 1'b0, 1'b0, 8'h51, 2'b11, 18'h0);
    step(3'b111, 1'b0, 1'b1, 8'h00, 2'b11, 18'h00AAA);
    step(3'b111, 1'b0, 1'b1, 8'h00, 2'b11, 18'h00BBB);
    step(3'b111, 1'b0, 1'b1, 8'h00, 2'b11, 18'h00CCC);
    step(3'b000, 1'b1, 1'b0, 8'h00, 2'b00, 18'h00DDD);
    // linear read burst from 0x53: 53,50,51,52
    interleave = 1'b0;
    step(3'b111, 1'b1, 1'b0, 8'h53, 2'b00, 18'h0);
    chk("R9 R8 burst word 0x53", 1'b1, 18'h00CCC);
    step(3'b111, 1'b1, 1'b1, 8'h00, 2'b00, 18'h0);
    chk("R9 R8 burst word 0x50", 1'b1, 18'h00BBB);
    step(3'b111, 1'b1, 1'b1, 8'h00, 2'b00, 18'h0);
    chk("R9 R8 burst word 0x51", 1'b1, 18'h00AAA);
    step(3'b111, 1'b1, 1'b1, 8'h00, 2'b00, 18'h0);
    chk("R9 R8 burst word 0x52", 1'b1, 18'h00DDD);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule